// File: doc/BRIEF.md
# Framebuffer Clear and Sprite Blit Sequencer

This block is the multi-cycle pixel engine of a small game-console processor. It owns the port to a 64 by 32 monochrome framebuffer that holds one bit per address and is reached through a column coordinate and a row coordinate. The framebuffer has no bulk-write path, so every pixel costs at least one clock.

A clear command sweeps the whole surface and writes a zero to every pixel, one per clock. A draw command overlays a sprite with exclusive-or. The sprite is up to fifteen rows of eight pixels, and each row is a byte fetched from main memory at a base pointer plus the row number. Each pixel is handled in two steps: the old bit is read, then the merged bit is written back. The engine reports a collision flag that the surrounding processor copies into its flag register.

The caller pulses a strobe together with the origin, the row count and the base pointer, then waits for the single-cycle completion pulse. Memory and framebuffer reads are combinational: the read data belongs to the address driven in the same cycle.

Top module: `fbs_engine`

## Requirements
- R1: While reset is asserted, and in the first idle cycles after it, `busy`, `done`, `fb_we` and `collide` are all low.
- R2: A clear command drives `fb_we`=1 and `fb_wdata`=0 in each of the 2048 cycles that follow the accepting edge. The coordinate starts at (0,0). X advances every cycle and Y advances when X wraps from 63 to 0, ending at (63,31).
- R3: After the last clear write, `done` is high for exactly one cycle with no write. A clear therefore keeps `busy` high for 2049 cycles.
- R4: For sprite row r, the draw spends one fetch cycle with no framebuffer write, driving `mem_addr` = (base + r) mod 4096. The byte on `mem_rdata` in that cycle is the row's pattern.
- R5: Each sprite pixel takes a read cycle (`fb_we`=0) followed by a write cycle at the same coordinate, with `fb_wdata` = old bit XOR sprite bit. Bit 7 of the row byte is column 0, the leftmost pixel, and bit 0 is column 7. Within a row the columns go left to right.
- R6: The pixel at sprite column c, row r sits at X = (origin X + c) mod 64 and Y = (origin Y + r) mod 32.
- R7: The row count is 4 bits wide (0 to 15). A draw of n rows keeps `busy` high for 17n+1 cycles, with `done` in the last of them. A count of 0 gives `done` in the first busy cycle and touches no pixel.
- R8: `collide` goes low when a draw is accepted. It is set if any written pixel changes from 1 to 0, and it is valid in the `done` cycle. It holds its value afterwards, and a clear leaves it unchanged, until the next draw is accepted.
- R9: A strobe is accepted only while `busy` is low. A strobe raised while busy has no effect on the running command, its outputs or its timing. If `clear_go` and `draw_go` are sampled together, the clear is performed.
- R10: `busy` rises in the cycle after the accepting edge and stays high through the `done` cycle. `done` lasts one cycle, and `fb_we` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_go | input | 1 | Start a full-screen clear |
| draw_go | input | 1 | Start a sprite draw |
| org_x | input | 6 | Sprite origin column |
| org_y | input | 5 | Sprite origin row |
| row_count | input | 4 | Sprite height in rows |
| sprite_base | input | 12 | Memory address of the first sprite row |
| mem_addr | output | 12 | Main memory read address |
| mem_rdata | input | 8 | Main memory read data for `mem_addr` |
| fb_x | output | 6 | Framebuffer column |
| fb_y | output | 5 | Framebuffer row |
| fb_we | output | 1 | Framebuffer write enable |
| fb_wdata | output | 1 | Framebuffer write bit |
| fb_rdata | input | 1 | Framebuffer read bit at (`fb_x`,`fb_y`) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| collide | output | 1 | Collision result of the last draw |

## Verification
The bench builds the engine with its default widths: a 6-bit column, a 5-bit row, a 4-bit row count and a 12-bit memory address. With these, the full 2048-pixel sweep, the maximum fifteen-row sprite, and the sprite crossing the right edge, the bottom edge and the top of the memory address space are all exercised at their real sizes. Redrawing an identical sprite sets the collision flag, and zero-height draws, simultaneous strobes and strobes raised mid-command reach the acceptance and priority corners.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_FETCH = 3'd2,
    ST_RD    = 3'd3,
    ST_WR    = 3'd4,
    ST_DONE  = 3'd5
  } fbs_state_e;
endpackage

// File: rtl/fbs_clear_scan.sv
module fbs_clear_scan #(
  parameter int XW = 6,
  parameter int YW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          last
);
  localparam logic [XW-1:0] X_MAX = '1;
  localparam logic [YW-1:0] Y_MAX = '1;

  logic [XW-1:0] x_d;
  logic [YW-1:0] y_d;
  logic          en;

  assign en   = restart | step;
  assign last = (x == X_MAX) && (y == Y_MAX);

  always_comb begin
    x_d = x;
    y_d = y;
    if (restart) begin
      x_d = '0;
      y_d = '0;
    end else if (step) begin
      x_d = x + XW'(1);
      if (x == X_MAX) y_d = y + YW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (en) begin
      x <= x_d;
      y <= y_d;
    end
  end
endmodule

// File: rtl/fbs_sprite_walk.sv
module fbs_sprite_walk #(
  parameter int RW = 4,
  parameter int CB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          col_step,
  input  logic          row_step,
  input  logic [RW-1:0] rows,
  output logic [RW-1:0] row,
  output logic [CB-1:0] col,
  output logic          last_col,
  output logic          last_row
);
  localparam logic [CB-1:0] COL_MAX = '1;

  logic [RW-1:0] row_d;
  logic [CB-1:0] col_d;
  logic          en;

  assign en       = restart | col_step | row_step;
  assign last_col = (col == COL_MAX);
  assign last_row = (row == rows - RW'(1));

  always_comb begin
    row_d = row;
    col_d = col;
    if (restart) begin
      row_d = '0;
      col_d = '0;
    end else if (row_step) begin
      row_d = row + RW'(1);
      col_d = '0;
    end else if (col_step) begin
      col_d = col + CB'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (en) begin
      row <= row_d;
      col <= col_d;
    end
  end
endmodule

// File: rtl/fbs_pixel_merge.sv
module fbs_pixel_merge #(
  parameter int PW = 8,
  parameter int CB = 3
) (
  input  logic [PW-1:0] pattern,
  input  logic [CB-1:0] col,
  input  logic          old_bit,
  output logic          new_bit,
  output logic          hit
);
  localparam logic [CB-1:0] MSB_IDX = CB'(PW - 1);

  logic spr_bit;

  assign spr_bit = pattern[MSB_IDX - col];
  assign new_bit = old_bit ^ spr_bit;
  assign hit     = old_bit & spr_bit;
endmodule

// File: rtl/fbs_engine.sv
module fbs_engine #(
  parameter int XW = 6,
  parameter int YW = 5,
  parameter int RW = 4,
  parameter int AW = 12,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_go,
  input  logic          draw_go,
  input  logic [XW-1:0] org_x,
  input  logic [YW-1:0] org_y,
  input  logic [RW-1:0] row_count,
  input  logic [AW-1:0] sprite_base,
  output logic [AW-1:0] mem_addr,
  input  logic [PW-1:0] mem_rdata,
  output logic [XW-1:0] fb_x,
  output logic [YW-1:0] fb_y,
  output logic          fb_we,
  output logic          fb_wdata,
  input  logic          fb_rdata,
  output logic          busy,
  output logic          done,
  output logic          collide
);
  import fbs_pkg::*;

  localparam int CB = (PW > 1) ? $clog2(PW) : 1;

  fbs_state_e    state_q, state_d;
  logic [XW-1:0] ox_q;
  logic [YW-1:0] oy_q;
  logic [RW-1:0] rows_q;
  logic [AW-1:0] base_q;
  logic [PW-1:0] pat_q, pat_d;
  logic          old_q, old_d;
  logic          coll_q, coll_d;

  logic          cmd_load, pat_en, old_en, coll_en;
  logic          scan_restart, scan_step, scan_last;
  logic [XW-1:0] scan_x;
  logic [YW-1:0] scan_y;
  logic          walk_restart, col_step, row_step, last_col, last_row;
  logic [RW-1:0] row;
  logic [CB-1:0] col;
  logic          merged, hit;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;

  fbs_clear_scan #(.XW(XW), .YW(YW)) u_scan (
    .clk(clk), .rst_n(rst_n), .restart(scan_restart), .step(scan_step),
    .x(scan_x), .y(scan_y), .last(scan_last)
  );

  fbs_sprite_walk #(.RW(RW), .CB(CB)) u_walk (
    .clk(clk), .rst_n(rst_n), .restart(walk_restart), .col_step(col_step),
    .row_step(row_step), .rows(rows_q), .row(row), .col(col),
    .last_col(last_col), .last_row(last_row)
  );

  fbs_pixel_merge #(.PW(PW), .CB(CB)) u_merge (
    .pattern(pat_q), .col(col), .old_bit(old_q), .new_bit(merged), .hit(hit)
  );

  assign pix_x = ox_q + XW'(col);
  assign pix_y = oy_q + YW'(row);

  // next-state process
  always_comb begin
    state_d      = state_q;
    cmd_load     = 1'b0;
    scan_restart = 1'b0;
    scan_step    = 1'b0;
    walk_restart = 1'b0;
    col_step     = 1'b0;
    row_step     = 1'b0;
    pat_en       = 1'b0;
    old_en       = 1'b0;
    coll_en      = 1'b0;
    pat_d        = mem_rdata;
    old_d        = fb_rdata;
    coll_d       = coll_q;
    unique case (state_q)
      ST_IDLE: begin
        if (clear_go) begin
          scan_restart = 1'b1;
          state_d      = ST_CLEAR;
        end else if (draw_go) begin
          cmd_load     = 1'b1;
          walk_restart = 1'b1;
          coll_en      = 1'b1;
          coll_d       = 1'b0;
          state_d      = (row_count == '0) ? ST_DONE : ST_FETCH;
        end
      end
      ST_CLEAR: begin
        scan_step = 1'b1;
        if (scan_last) state_d = ST_DONE;
      end
      ST_FETCH: begin
        pat_en  = 1'b1;
        state_d = ST_RD;
      end
      ST_RD: begin
        old_en  = 1'b1;
        state_d = ST_WR;
      end
      ST_WR: begin
        if (hit) begin
          coll_en = 1'b1;
          coll_d  = 1'b1;
        end
        if (!last_col) begin
          col_step = 1'b1;
          state_d  = ST_RD;
        end else if (last_row) begin
          state_d = ST_DONE;
        end else begin
          row_step = 1'b1;
          state_d  = ST_FETCH;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ox_q    <= '0;
      oy_q    <= '0;
      rows_q  <= '0;
      base_q  <= '0;
      pat_q   <= '0;
      old_q   <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_load) begin
        ox_q   <= org_x;
        oy_q   <= org_y;
        rows_q <= row_count;
        base_q <= sprite_base;
      end
      if (pat_en)  pat_q  <= pat_d;
      if (old_en)  old_q  <= old_d;
      if (coll_en) coll_q <= coll_d;
    end
  end

  assign mem_addr = base_q + AW'(row);
  assign fb_x     = (state_q == ST_CLEAR) ? scan_x : pix_x;
  assign fb_y     = (state_q == ST_CLEAR) ? scan_y : pix_y;
  assign fb_we    = (state_q == ST_CLEAR) || (state_q == ST_WR);
  assign fb_wdata = (state_q == ST_WR) ? merged : 1'b0;
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign collide  = coll_q;
endmodule

// File: rtl/fbs_engine_chk.sv
module fbs_engine_chk #(
  parameter int XW = 6,
  parameter int YW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fb_we,
  input logic          fb_wdata,
  input logic [XW-1:0] fb_x,
  input logic [YW-1:0] fb_y,
  input logic          collide
);
  // R10: no write outside a command
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fb_we);

  // R10: completion pulse lasts one cycle and lies inside busy
  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a running command is not cut short by anything before its done
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  // R3: the done cycle carries no write
  a_r3_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fb_we);

  // R2: back-to-back writes only occur in the sweep, X fastest, zero data
  a_r2_sweep_order: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we && $past(fb_we) |->
      !fb_wdata && (fb_x == $past(fb_x) + XW'(1)) &&
      (fb_y == $past(fb_y) + YW'(fb_x == '0)));

  // R5: a write of one is preceded by a read cycle at the same pixel
  a_r5_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we && fb_wdata |->
      !$past(fb_we) && (fb_x == $past(fb_x)) && (fb_y == $past(fb_y)));

  // R8: flag low in the first cycle of a draw, stable while idle
  a_r8_clear_on_draw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !fb_we |-> !collide);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) |-> $stable(collide));
endmodule

bind fbs_engine fbs_engine_chk #(.XW(XW), .YW(YW)) u_fbs_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fb_we(fb_we),
  .fb_wdata(fb_wdata), .fb_x(fb_x), .fb_y(fb_y), .collide(collide)
);

// File: tb/test_fbs_engine.sv
`timescale 1ns/1ps
module test_fbs_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear_go, draw_go;
  logic [5:0]  org_x;
  logic [4:0]  org_y;
  logic [3:0]  row_count;
  logic [11:0] sprite_base;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [5:0]  fb_x;
  logic [4:0]  fb_y;
  logic        fb_we, fb_wdata, fb_rdata;
  logic        busy, done, collide;

  logic [7:0] smem [0:4095];
  logic       fb_mem [0:2047];
  bit         fref [0:2047];

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fbs_engine i_fbs_engine (
    .clk(clk), .rst_n(rst_n), .clear_go(clear_go), .draw_go(draw_go),
    .org_x(org_x), .org_y(org_y), .row_count(row_count),
    .sprite_base(sprite_base), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .fb_x(fb_x), .fb_y(fb_y), .fb_we(fb_we), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata), .busy(busy), .done(done), .collide(collide)
  );

  assign mem_rdata = smem[mem_addr];
  assign fb_rdata  = fb_mem[{fb_y, fb_x}];

  always @(posedge clk) begin
    if (fb_we) fb_mem[{fb_y, fb_x}] <= fb_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference model, compared every clock
  int   mmode = 0;   // 0 idle, 1 clear, 2 draw
  int   mk, mrows, mox, moy, mbase;
  logic [7:0] mbyte;
  bit   coll_exp = 0;

  function automatic int last_k();
    return (mmode == 1) ? 2048 : 17 * mrows;
  endfunction

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      mmode = 0;
      coll_exp = 0;
      chk(!busy && !done && !fb_we && !collide, "R1", {busy, done, fb_we, collide}, 0);
    end else begin
      automatic bit was_idle = (mmode == 0);
      if (mmode != 0) begin
        mk++;
        if (mk > last_k()) mmode = 0;
      end
      if (was_idle && (clear_go || draw_go)) begin
        mk = 0;
        if (clear_go) mmode = 1;   // R9 priority to clear
        else begin
          mmode = 2;
          mrows = row_count;
          mox = org_x; moy = org_y; mbase = sprite_base;
          coll_exp = 0;
        end
      end
      chk(collide == coll_exp, "R8", collide, coll_exp);
      if (mmode == 0) begin
        chk(!busy && !done && !fb_we, "R10", {busy, done, fb_we}, 0);
      end else if (mk == last_k()) begin
        chk(busy && done && !fb_we, (mmode == 1) ? "R3" : "R7", {busy, done, fb_we}, 6);
      end else if (mmode == 1) begin
        chk(busy && !done, "R3", {busy, done}, 2);
        chk(fb_we && !fb_wdata, "R2", {fb_we, fb_wdata}, 2);
        chk(fb_x == mk % 64 && fb_y == mk / 64, "R2", {fb_y, fb_x}, mk);
        fref[mk] = 0;
      end else begin
        automatic int r = mk / 17;
        automatic int m = mk % 17;
        chk(busy && !done, "R7", {busy, done}, 2);
        if (m == 0) begin
          chk(!fb_we, "R4", fb_we, 0);
          chk(mem_addr == (mbase + r) % 4096, "R4", mem_addr, (mbase + r) % 4096);
          mbyte = smem[(mbase + r) % 4096];
        end else begin
          automatic int c  = (m - 1) / 2;
          automatic int ex = (mox + c) % 64;
          automatic int ey = (moy + r) % 32;
          chk(fb_x == ex && fb_y == ey, "R6", {fb_y, fb_x}, ey * 64 + ex);
          if ((m - 1) % 2 == 0) begin
            chk(!fb_we, "R5", fb_we, 0);
          end else begin
            automatic bit b   = mbyte[7 - c];
            automatic bit old = fref[ey * 64 + ex];
            chk(fb_we && fb_wdata == (old ^ b), "R5", {fb_we, fb_wdata}, {1'b1, old ^ b});
            if (old && b) coll_exp = 1;
            fref[ey * 64 + ex] = old ^ b;
          end
        end
      end
    end
  end

  task automatic issue(input bit c, input bit d, input int ox, input int oy,
                       input int n, input int base);
    @(negedge clk);
    clear_go = c; draw_go = d;
    org_x = 6'(ox); org_y = 5'(oy); row_count = 4'(n); sprite_base = 12'(base);
    @(negedge clk);
    clear_go = 0; draw_go = 0;
  endtask

  task automatic wait_idle(input string req);
    int bad = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 2048; i++) if (fb_mem[i] !== fref[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL R10 watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) smem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 2048; i++) begin
      fb_mem[i] = ((i % 3) == 0);
      fref[i]   = ((i % 3) == 0);
    end
    smem[12'h100] = 8'hFF; smem[12'h101] = 8'h81; smem[12'h102] = 8'h3C;
    rst_n = 0; clear_go = 0; draw_go = 0;
    org_x = 0; org_y = 0; row_count = 0; sprite_base = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3: full sweep over a patterned screen
    issue(1, 0, 0, 0, 0, 0);
    wait_idle("R2");
    // R4 R5: three-row sprite on a blank screen, no collision
    issue(0, 1, 10, 5, 3, 12'h100);
    wait_idle("R5");
    chk(collide == 0, "R8", collide, 0);
    // R8: identical redraw erases it and reports a collision
    issue(0, 1, 10, 5, 3, 12'h100);
    wait_idle("R5");
    chk(collide == 1, "R8", collide, 1);
    // R8: a clear leaves the flag alone
    issue(1, 0, 0, 0, 0, 0);
    wait_idle("R2");
    chk(collide == 1, "R8", collide, 1);
    // R6 R4: fifteen rows across both screen edges and the address top
    issue(0, 1, 60, 30, 15, 12'hFF8);
    wait_idle("R6");
    // R7: zero-height draw
    issue(0, 1, 3, 3, 0, 12'h200);
    wait_idle("R7");
    // R9: both strobes, clear wins
    issue(1, 1, 7, 7, 4, 12'h300);
    wait_idle("R9");
    // R9: strobes during a draw are ignored
    issue(0, 1, 20, 10, 5, 12'h040);
    repeat (7) @(negedge clk);
    issue(0, 1, 1, 1, 9, 12'h500);
    issue(1, 0, 0, 0, 0, 0);
    wait_idle("R9");
    // R9: draw strobe during a clear is ignored
    issue(1, 0, 0, 0, 0, 0);
    repeat (100) @(negedge clk);
    issue(0, 1, 5, 5, 2, 12'h100);
    wait_idle("R9");
    issue(0, 1, 62, 0, 2, 12'h100);
    wait_idle("R6");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule